// File: doc/BRIEF.md
# Cascadable Serial-Load Switch Control Register

This block is the digital control front end for a bank of sixteen on/off switches. Control bits arrive one at a time on a serial input and move through a sixteen-stage shift register on each rising clock edge. A bank of level-sensitive latches sits between the shift register and the switch-control outputs. A single hold input decides whether the latches follow the register or keep their state. Each switch is modelled as one logic output bit: 1 means ON and 0 means OFF.

The last stage of the shift register drives a serial output. Several instances can be chained by wiring each serial output to the next serial input on a shared clock. A full load then takes sixteen clocks per instance.

A typical load holds the latches closed, clocks in the whole word with the most significant bit first, and then opens the latches briefly. An asynchronous clear input empties both the register and the latches and turns every output OFF at once. The clear wins over the hold input and over the clock.

Top module: `serial_switch_bank`

## Requirements
- R1: On each rising clock edge with clear low, stage n+1 takes the old value of stage n and stage 0 takes the serial input, for stages 0 to 15.
- R2: Output swCtl[i] is the control bit for switch i, with 1 meaning ON and 0 meaning OFF. After sixteen bits are sent most significant bit first and the latches are opened, word bit i appears on swCtl[i].
- R3: While clrAsync is high, every stage, every latch, swCtl and serOut are 0 at once. This holds whatever latchHold, serIn and clk are doing.
- R4: While latchHold is high, swCtl keeps its value through any number of clock edges and serial input changes.
- R5: While latchHold is low and clear is low, swCtl follows the shift register stage by stage, so the outputs change as data is shifted in.
- R6: serOut carries stage 15, so the first bit shifted in after a clear appears on serOut after the sixteenth rising edge and not before.
- R7: Two instances chained serOut to serIn on one clock take a 32-bit word most significant bit first in 32 clocks. The upper half then lands on the second instance and the lower half on the first.
- R8: After clear is released with latchHold high, the outputs stay 0 during shifting until latchHold goes low. Once it is low, they show the stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the rising edge moves data one stage |
| clrAsync | input | 1 | Asynchronous clear, active high; clears stages and latches |
| latchHold | input | 1 | High: latches keep their value; low: latches are transparent |
| serIn | input | 1 | Serial control data into stage 0 |
| serOut | output | 1 | Content of the last stage, for chaining |
| swCtl | output | STAGES | Switch-control outputs, 1 = ON |

## Verification
A table of 32-bit words is loaded through a chain of two instances with the latches held, and then released. The words include all zeros, all ones, single set bits at both ends, alternating nibbles and a mixed value. Together they separate a reversed bit order, a swapped half between instances, a stuck stage and a skipped stage. Other tests cover the latches:
- A transparent shift of an irregular pattern, compared after every edge, tells a latch that lags or ignores its stage apart from a correct one.
- A single marker bit timed to the sixteenth edge catches an off-by-one in the register length.
- A clear in the middle of a load shows whether the clear reaches the latches, the register and the serial output, even while the hold input is active.

// File: rtl/ssb_pkg.sv
`timescale 1ns/1ps
package ssb_pkg;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic clearAll;   // asynchronous wipe of stages and latches
    logic latchOpen;  // latches transparent
  } ssbStrobe_t;

endpackage

// File: rtl/ssb_ctrl.sv
`timescale 1ns/1ps
module ssb_ctrl
  import ssb_pkg::*;
(
  input  logic       clrAsync,
  input  logic       latchHold,
  output ssbStrobe_t strobe
);

  // Clear overrides the hold input (R3): the latches only open when no clear is active.
  always_comb begin
    strobe.clearAll  = clrAsync;
    strobe.latchOpen = ~latchHold & ~clrAsync;
  end

endmodule

// File: rtl/ssb_shift_path.sv
`timescale 1ns/1ps
module ssb_shift_path
  import ssb_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic              clk,
  input  ssbStrobe_t        strobe,
  input  logic              serIn,
  output logic [STAGES-1:0] stageBits,
  output logic              lastBit
);

  localparam int LAST = STAGES - 1;

  // R1: stage 0 loads the serial input; every other stage loads its neighbour.
  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    logic nextBit;
    if (gi == 0) begin : g_head
      assign nextBit = serIn;
    end else begin : g_body
      assign nextBit = stageBits[gi-1];
    end
    always_ff @(posedge clk or posedge strobe.clearAll) begin
      if (strobe.clearAll) stageBits[gi] <= 1'b0;   // R3
      else                 stageBits[gi] <= nextBit;
    end
  end

  assign lastBit = stageBits[LAST];   // R6

endmodule

// File: rtl/ssb_latch_bank.sv
`timescale 1ns/1ps
module ssb_latch_bank
  import ssb_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  ssbStrobe_t        strobe,
  input  logic [STAGES-1:0] stageBits,
  output logic [STAGES-1:0] swCtl
);

  // One level-sensitive cell per switch: clear first, then transparency (R3, R4, R5).
  for (genvar gi = 0; gi < STAGES; gi++) begin : g_cell
    always_latch begin
      if (strobe.clearAll)       swCtl[gi] <= 1'b0;
      else if (strobe.latchOpen) swCtl[gi] <= stageBits[gi];
    end
  end

endmodule

// File: rtl/serial_switch_bank.sv
`timescale 1ns/1ps
module serial_switch_bank
  import ssb_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic              clk,
  input  logic              clrAsync,
  input  logic              latchHold,
  input  logic              serIn,
  output logic              serOut,
  output logic [STAGES-1:0] swCtl
);

  ssbStrobe_t        strobe;
  logic [STAGES-1:0] stageBits;

  ssb_ctrl u_ctrl (
    .clrAsync  (clrAsync),
    .latchHold (latchHold),
    .strobe    (strobe)
  );

  ssb_shift_path #(.STAGES(STAGES)) u_shift (
    .clk       (clk),
    .strobe    (strobe),
    .serIn     (serIn),
    .stageBits (stageBits),
    .lastBit   (serOut)
  );

  ssb_latch_bank #(.STAGES(STAGES)) u_latch (
    .strobe    (strobe),
    .stageBits (stageBits),
    .swCtl     (swCtl)
  );

endmodule

// File: rtl/ssb_chk.sv
`timescale 1ns/1ps
module ssb_chk #(
  parameter int STAGES = 16
) (
  input logic              clk,
  input logic              clrAsync,
  input logic              latchHold,
  input logic              serIn,
  input logic              serOut,
  input logic [STAGES-1:0] swCtl,
  input logic [STAGES-1:0] stages
);

  logic              pastOk;
  logic              holdAtEdge;
  logic [STAGES-1:0] snapOut;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) pastOk <= 1'b0;
    else          pastOk <= 1'b1;
  end

  always_ff @(posedge clk) begin
    snapOut    <= swCtl;
    holdAtEdge <= latchHold & ~clrAsync;
  end

  // R1
  shift_step_chk: assert property (@(posedge clk) disable iff (clrAsync)
    pastOk |-> stages == {$past(stages[STAGES-2:0]), $past(serIn)});

  // R6
  tail_out_chk: assert property (@(posedge clk) disable iff (clrAsync)
    pastOk |-> serOut == $past(stages[STAGES-2]));

  always @(negedge clk) begin
    // R3
    if (clrAsync) begin
      clear_all_chk: assert (swCtl == '0 && serOut == 1'b0 && stages == '0);
    end
    // R4
    if (holdAtEdge && latchHold && !clrAsync) begin
      hold_keep_chk: assert (swCtl == snapOut);
    end
    // R5
    if (!latchHold && !clrAsync) begin
      follow_chk: assert (swCtl == stages);
    end
  end

endmodule

bind serial_switch_bank ssb_chk #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .clrAsync  (clrAsync),
  .latchHold (latchHold),
  .serIn     (serIn),
  .serOut    (serOut),
  .swCtl     (swCtl),
  .stages    (stageBits)
);

// File: tb/serial_switch_bank_tb.sv
`timescale 1ns/1ps
module serial_switch_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int N          = 16;
  localparam int NVEC       = 6;
  localparam logic [31:0] VECS [NVEC] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
    32'hA5A5_5A5A, 32'h0001_8000, 32'h1234_ABCD
  };

  logic clk = 1'b0, clr = 1'b1, hold = 1'b1, serIn = 1'b0;
  logic s0, s1;
  logic [N-1:0] sw0, sw1;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  serial_switch_bank #(.STAGES(N)) u_dut (
    .clk(clk), .clrAsync(clr), .latchHold(hold), .serIn(serIn),
    .serOut(s0), .swCtl(sw0));

  serial_switch_bank #(.STAGES(N)) u_dut2 (
    .clk(clk), .clrAsync(clr), .latchHold(hold), .serIn(s0),
    .serOut(s1), .swCtl(sw1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock burst; outputs are settled when it returns.
  task automatic tick();
    #HALF clk = 1'b1;
    #HALF clk = 1'b0;
    #1;
  endtask

  task automatic sendBits(input logic [31:0] word, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      serIn = word[i];
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    logic [N-1:0] model;
    logic [N-1:0] pat;

    // Reset state, R3
    hold = 1'b0;
    #3;
    check("R3 reset outputs", {sw1, sw0}, 32'h0);
    check("R3 reset serOut", {30'h0, s1, s0}, 32'h0);
    clr = 1'b0;
    #2;

    // R6: marker bit reaches serOut only on the 16th edge; held outputs stay 0 (R4)
    hold = 1'b1;
    serIn = 1'b1;
    tick();
    serIn = 1'b0;
    for (int i = 0; i < 14; i++) tick();
    check("R6 serOut after 15 edges", {31'h0, s0}, 32'h0);
    tick();
    check("R6 serOut after 16 edges", {31'h0, s0}, 32'h1);
    check("R4 held outputs during marker", {16'h0, sw0}, 32'h0);

    // R5 and R1: transparent shifting, compared after every edge
    clr = 1'b1; #1; clr = 1'b0; #1;
    hold = 1'b0;
    model = '0;
    pat = 16'hC3A1;
    for (int i = N - 1; i >= 0; i--) begin
      serIn = pat[i];
      tick();
      model = {model[N-2:0], pat[i]};
      check("R5 R1 transparent follow", {16'h0, sw0}, {16'h0, model});
    end
    check("R2 single-instance word", {16'h0, sw0}, {16'h0, pat});

    // Chain table: R7, R2, R4, R6
    clr = 1'b1; #1; clr = 1'b0; #1;
    hold = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      prev = {sw1, sw0};
      sendBits(VECS[v], 32);
      check("R4 outputs held during chain load", {sw1, sw0}, prev);
      check("R6 chain tail carries first bit", {31'h0, s1}, {31'h0, VECS[v][31]});
      hold = 1'b0;
      #1;
      check("R7 R2 chained word on outputs", {sw1, sw0}, VECS[v]);
      hold = 1'b1;
      #1;
    end

    // R3: clear mid-load with hold high overrides the latches
    sendBits(32'h3FF, 10);
    clr = 1'b1;
    #1;
    check("R3 clear mid-load outputs", {sw1, sw0}, 32'h0);
    check("R3 clear mid-load serOut", {30'h0, s1, s0}, 32'h0);
    serIn = 1'b1;
    hold = 1'b0;
    tick();
    check("R3 clock during clear", {sw1, sw0}, 32'h0);
    check("R3 serOut during clear", {30'h0, s1, s0}, 32'h0);

    // R8: held after clear release, then opened
    hold = 1'b1;
    #1;
    clr = 1'b0;
    #1;
    for (int i = 0; i < 4; i++) tick();
    check("R8 held zero after clear", {sw1, sw0}, 32'h0);
    hold = 1'b0;
    #1;
    check("R8 open shows stages", {sw1, sw0}, 32'h0000_000F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule